// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Target

This block is a two-wire (I2C) bus target that serves the read side of a byte-wide serial memory. It has 8192 locations. A master first sends a write-type device address and then two address bytes that carry no data. These bytes load an internal location pointer. The master then issues a repeated START with a read-type device address and clocks out data bytes, MSB first. Each master acknowledge fetches the following location. The pointer rolls from the top location back to zero.

A read-type device address sent straight after START reads from wherever the pointer currently rests. The pointer advances after every byte sent, so consecutive plain reads walk through the array. The device address is the fixed nibble 1010, then three bits compared against the strap inputs, then the direction bit. A separate synchronous port fills the array, standing in for non-volatile contents.

Both bus lines are oversampled by the system clock through a two-stage synchronizer. START and STOP are recognised from SDA edges while SCL is high. Either one, seen at any point, drops the transfer in progress and leaves the pointer unchanged.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: The target acknowledges a device address byte only when its bits 7..4 are 1010 and bits 3..1 equal `sel_i`. With any other byte it drives nothing until the next START.
- R2: After a matching device byte with bit 0 = 0, the target acknowledges the next two bytes. The low 13 bits of those 16 bits, taken MSB first, load the pointer. The top 3 bits of the first byte are ignored.
- R3: A repeated START followed by a matching device byte with bit 0 = 1 makes the target send the byte stored at the loaded pointer, D7 first.
- R4: A master acknowledge (SDA low on the ninth clock) after a data byte makes the target send the byte at the next location.
- R5: Reading past location 8191 continues at location 0.
- R6: A master NO-ACK (SDA high on the ninth clock) ends the burst. The target releases SDA (`sda_oe` = 0) and stays released after the following STOP. `sda_oe` is 0 out of reset.
- R7: The pointer advances after every byte sent. A later read that starts directly after START continues from the location after the last byte sent.
- R8: The low level the target puts on SDA changes only while SCL is low.
- R9: A START or STOP in the middle of a transfer abandons it, and the pointer keeps its previous value.
- R10: A write on the preload port (`pre_we` = 1 for one clock) replaces the byte at `pre_addr` with `pre_data`, and later reads return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Data bit presented by the target |
| sda_oe | output | 1 | High while the target drives SDA |
| sel_i | input | 3 | Strap bits compared with device address bits 3..1 |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 13 | Preload location |
| pre_data | input | 8 | Preload byte |

## Verification
The embedded properties assume a well-behaved master. It changes SDA only while SCL is low, except when it forms START and STOP. It issues those only while the target has released the line, which means after a NO-ACK or between address phases. Each SCL phase is held for several system clocks. The bench keeps to this by generating every bus event in the same fixed sequence of quarter-bit steps, four system clocks each. Random choices vary only addresses, burst lengths, don't-care address bits and whether the strap bits match.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    localparam int unsigned MEM_AW   = 13;
    localparam int unsigned MEM_DW   = 8;
    localparam int unsigned SYNC_LEN = 2;
    localparam logic [3:0]  DEV_TAG  = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_ACK,
        ST_HOLD,
        ST_RD,
        ST_RACK
    } rd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
        logic scl;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] sel);
        return (b[7:4] == DEV_TAG) && (b[3:1] == sel);
    endfunction

endpackage

// File: rtl/i2c_rd_lines.sv
module i2c_rd_lines
    import i2c_rd_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_LEN
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s = scl_p[STAGES-1];
    assign sda_s = sda_p[STAGES-1];

    always_comb begin
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
        ev.sda   = sda_s;
        ev.scl   = scl_s;
    end

endmodule

// File: rtl/i2c_rd_store.sv
module i2c_rd_store #(
    parameter int unsigned AW = 13,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/i2c_rd_ptr.sv
module i2c_rd_ptr #(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (ld)  ptr <= ld_val;
        else if (inc) ptr <= ptr + AW'(1);
    end

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr) |-> ($past(ld) || ptr == $past(ptr) + AW'(1)));

    // R5
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (inc && !ld && ptr == '1) |=> ptr == '0);

endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
    import i2c_rd_pkg::*;
#(
    parameter int unsigned ADDR_W = MEM_AW,
    parameter int unsigned DATA_W = MEM_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic [2:0]        sel_i,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data
);
    localparam int unsigned HI_W  = ADDR_W - DATA_W;
    localparam logic [3:0]  FULL  = 4'(DATA_W);

    bus_ev_t             ev;
    rd_state_e           st, nxt;
    logic [3:0]          cnt;
    logic [DATA_W-1:0]   sh, tx;
    logic [HI_W-1:0]     hi;
    logic                ack_m;
    logic                ptr_ld, ptr_inc;
    logic [ADDR_W-1:0]   ld_val, ptr;
    logic [DATA_W-1:0]   mem_q;
    logic                oe_r, o_r;

    i2c_rd_lines #(.STAGES(SYNC_LEN)) u_lines (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c_rd_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(pre_we), .wr_addr(pre_addr),
        .wr_data(pre_data), .rd_addr(ptr), .rd_data(mem_q)
    );

    i2c_rd_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst(rst), .ld(ptr_ld), .ld_val(ld_val),
        .inc(ptr_inc), .ptr(ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            nxt     <= ST_IDLE;
            cnt     <= '0;
            sh      <= '0;
            tx      <= '0;
            hi      <= '0;
            ack_m   <= 1'b0;
            ptr_ld  <= 1'b0;
            ptr_inc <= 1'b0;
            ld_val  <= '0;
            oe_r    <= 1'b0;
            o_r     <= 1'b1;
        end else begin
            ptr_ld  <= 1'b0;
            ptr_inc <= 1'b0;
            if (ev.stop) begin
                st   <= ST_IDLE;
                oe_r <= 1'b0;
                o_r  <= 1'b1;
            end else if (ev.start) begin
                st   <= ST_DEV;
                cnt  <= '0;
                oe_r <= 1'b0;
                o_r  <= 1'b1;
            end else begin
                case (st)
                    ST_DEV, ST_AHI, ST_ALO: begin
                        if (ev.rise && cnt != FULL) begin
                            sh  <= {sh[DATA_W-2:0], ev.sda};
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall && cnt == FULL) begin
                            cnt <= '0;
                            if (st == ST_DEV) begin
                                if (dev_hit(sh, sel_i)) begin
                                    st   <= ST_ACK;
                                    oe_r <= 1'b1;
                                    o_r  <= 1'b0;
                                    nxt  <= sh[0] ? ST_RD : ST_AHI;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else if (st == ST_AHI) begin
                                hi   <= sh[HI_W-1:0];
                                st   <= ST_ACK;
                                oe_r <= 1'b1;
                                o_r  <= 1'b0;
                                nxt  <= ST_ALO;
                            end else begin
                                ptr_ld <= 1'b1;
                                ld_val <= {hi, sh};
                                st     <= ST_ACK;
                                oe_r   <= 1'b1;
                                o_r    <= 1'b0;
                                nxt    <= ST_HOLD;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            st  <= nxt;
                            if (nxt == ST_RD) begin
                                tx   <= mem_q;
                                o_r  <= mem_q[DATA_W-1];
                                oe_r <= 1'b1;
                            end else begin
                                oe_r <= 1'b0;
                                o_r  <= 1'b1;
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (ev.fall) begin
                            if (cnt == FULL) begin
                                ptr_inc <= 1'b1;
                                st      <= ST_RACK;
                                oe_r    <= 1'b0;
                                o_r     <= 1'b1;
                                cnt     <= '0;
                            end else begin
                                tx  <= {tx[DATA_W-2:0], 1'b0};
                                o_r <= tx[DATA_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            ack_m <= ~ev.sda;
                        end else if (ev.fall) begin
                            if (ack_m) begin
                                st   <= ST_RD;
                                tx   <= mem_q;
                                o_r  <= mem_q[DATA_W-1];
                                oe_r <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_o  = o_r;
    assign sda_oe = oe_r;

    logic drv_low;
    assign drv_low = sda_oe & ~sda_o;

    // R8
    low_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(drv_low) |-> !ev.scl);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    // R1
    drive_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.fall));

    // R3
    rd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RD && $past(st) == ST_ACK) |-> sda_oe);

endmodule

// File: tb/i2c_eeprom_rd_bench.sv
module i2c_eeprom_rd_bench;
    localparam int AW    = 13;
    localparam int DEPTH = 1 << AW;
    localparam int Q     = 4;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          scl = 1'b1, msda = 1'b1;
    logic [2:0]    sel = SEL;
    logic          pwe = 1'b0;
    logic [AW-1:0] pa = '0;
    logic [7:0]    pd = '0;
    logic          sda_o, sda_oe;
    logic          line;
    assign line = msda & ~(sda_oe & ~sda_o);

    i2c_eeprom_rd u_i2c_eeprom_rd (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line),
        .sda_o(sda_o), .sda_oe(sda_oe), .sel_i(sel),
        .pre_we(pwe), .pre_addr(pa), .pre_data(pd)
    );

    logic [7:0] model [DEPTH];
    int ctr_m = 0;
    int n_chk = 0, n_bad = 0, viol = 0;
    logic drv_prev = 1'b0;

    always @(negedge clk) begin
        if (((sda_oe & ~sda_o) != drv_prev) && scl && !rst) viol++;
        drv_prev <= sda_oe & ~sda_o;
    end

    function automatic logic [7:0] fill(input int a);
        return 8'((a * 29) ^ (a >> 5) ^ 8'h5A);
    endfunction

    function automatic logic [7:0] dev(input logic [2:0] s, input logic rw);
        return {4'b1010, s, rw};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(Q);
        scl  = 1'b1; tick(Q);
        msda = 1'b0; tick(Q);
        scl  = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(Q);
        scl  = 1'b1; tick(Q);
        msda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        msda = b;    tick(Q);
        scl  = 1'b1; tick(2 * Q);
        scl  = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        msda = 1'b1; tick(Q);
        scl  = 1'b1; tick(Q);
        b = line;    tick(Q);
        scl  = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rd_byte(output logic [7:0] v, input logic more);
        logic b;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            v = {v[6:0], b};
        end
        send_bit(!more);
    endtask

    task automatic burst(input int n, input string req);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            rd_byte(v, k != n - 1);
            chk(v == model[ctr_m], req, int'(v), int'(model[ctr_m]));
            ctr_m = (ctr_m + 1) % DEPTH;
        end
        bus_stop();
    endtask

    task automatic set_addr(input int a, input logic [2:0] junk);
        logic a1, a2, a3;
        logic [AW-1:0] av;
        av = AW'(a);
        bus_start();
        wr_byte(dev(SEL, 1'b0), a1);
        wr_byte({junk, av[12:8]}, a2);
        wr_byte(av[7:0], a3);
        // R2: all three write-phase bytes acknowledged
        chk(a1 && a2 && a3, "R2", {a1, a2, a3}, 3'b111);
        ctr_m = a;
    endtask

    task automatic rand_read(input int a, input int n, input logic [2:0] junk, input string req);
        logic ak;
        set_addr(a, junk);
        bus_start();
        wr_byte(dev(SEL, 1'b1), ak);
        chk(ak, "R1", ak, 1);
        burst(n, req);
    endtask

    task automatic cur_read(input int n, input string req);
        logic ak;
        bus_start();
        wr_byte(dev(SEL, 1'b1), ak);
        chk(ak, "R1", ak, 1);
        burst(n, req);
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        pwe = 1'b1; pa = AW'(a); pd = v;
        tick(1);
        pwe = 1'b0;
        model[a] = v;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        logic ak;
        logic [7:0] v;
        void'($urandom(32'd4711));
        tick(4);
        rst = 1'b0;
        tick(2);
        // R6: released out of reset
        chk(sda_oe == 1'b0, "R6", sda_oe, 0);

        for (int a = 0; a < DEPTH; a++) poke(a, fill(a));
        tick(4);

        // R3: directed random read, junk in the upper address bits (R2)
        rand_read(1234, 1, 3'b111, "R3");
        // R4: sequential burst
        rand_read(40, 5, 3'b010, "R4");
        // R7: plain read continues after the burst
        cur_read(2, "R7");
        // R5: wrap from the top location
        rand_read(DEPTH - 2, 4, 3'b000, "R5");
        chk(ctr_m == 2, "R5", ctr_m, 2);
        cur_read(1, "R7");

        // R6: after NO-ACK and STOP the line stays released
        tick(20);
        chk(sda_oe == 1'b0 && line == 1'b1, "R6", {sda_oe, line}, 2'b01);

        // R1: wrong strap bits ignored
        bus_start();
        wr_byte(dev(SEL ^ 3'b011, 1'b1), ak);
        chk(!ak, "R1", ak, 0);
        tick(Q);
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        bus_stop();
        // R1: wrong fixed nibble ignored
        bus_start();
        wr_byte({4'b1011, SEL, 1'b1}, ak);
        chk(!ak, "R1", ak, 0);
        bus_stop();

        // R9: STOP after only the high address byte keeps the pointer
        bus_start();
        wr_byte(dev(SEL, 1'b0), ak);
        wr_byte(8'h1F, ak);
        bus_stop();
        cur_read(1, "R9");
        // R9: repeated START mid-address, then read from kept pointer
        bus_start();
        wr_byte(dev(SEL, 1'b0), ak);
        wr_byte(8'h05, ak);
        bus_start();
        wr_byte(dev(SEL, 1'b1), ak);
        chk(ak, "R9", ak, 1);
        burst(2, "R9");

        // R10: preload overrides contents
        poke(777, 8'hC3);
        poke(778, 8'h3C);
        rand_read(777, 2, 3'b101, "R10");

        for (int it = 0; it < 20; it++) begin
            int a, n;
            a = int'($urandom % DEPTH);
            n = 1 + int'($urandom % 4);
            if ($urandom % 4 == 0) begin
                bus_start();
                wr_byte(dev(SEL ^ 3'(1 + $urandom % 7), 1'b0), ak);
                // R1: mismatch never acknowledged
                chk(!ak, "R1", ak, 0);
                bus_stop();
            end else if ($urandom % 3 == 0) begin
                cur_read(n, "R7");
            end else begin
                rand_read(a, n, 3'($urandom), "R4");
            end
        end

        // R8: SDA drive never changed while SCL high
        chk(viol == 0, "R8", viol, 0);
        v = 8'h00;
        finish_run();
    end

endmodule